// File: doc/BRIEF.md
# Accumulator ALU with Gated Sign and Zero Flags

This unit is the arithmetic and logic slice of a small processor. It holds an 8-bit accumulator and carries out one operation per cycle when told to. The operations are add, subtract, increment, decrement, AND, OR, XOR, complement, rotate left and rotate right. For the two-operand operations, the second operand is either a byte read from a named register or an immediate byte taken from the instruction stream. Increment and decrement work on the named register rather than on the accumulator. For those two, the unit returns the new value on its result port and raises a write enable, so that the surrounding register file can store it.

The unit has only two flags: sign and zero. They are registered, and they take a new value only in a cycle whose load-flags strobe is high. The sign flag takes the top bit of the result. The zero flag is high when every result bit is zero. When the strobe is low, the flags keep their value whatever the result. This lets a decoder decide for each instruction whether a later conditional branch may see its outcome. All arithmetic wraps modulo 256, and no carry is kept.

Top module: `acc_alu_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator, the sign flag and the zero flag at that edge.
- R2: Opcode 0 (add) loads the accumulator with (acc + operand) mod 256 at the edge. The operand is imm_val when use_imm is 1 and reg_val when use_imm is 0.
- R3: Opcode 1 (subtract) loads the accumulator with (acc − operand) mod 256, with the operand chosen as in R2.
- R4: Opcode 2 (increment) and opcode 3 (decrement) put (reg_val ± 1) mod 256 on result in the same cycle and raise reg_we. imm_val and use_imm have no effect, and the accumulator does not change. reg_we is low for every other opcode.
- R5: Opcodes 4, 5 and 6 load the accumulator with the bitwise AND, OR and XOR, in that order, of the accumulator and the operand chosen as in R2.
- R6: Opcode 7 (complement) loads the accumulator with every bit inverted. Both operand inputs are ignored.
- R7: Opcode 8 (rotate left) moves each bit one place toward the MSB, and the old bit 7 enters bit 0.
- R8: Opcode 9 (rotate right) moves each bit one place toward the LSB, and the old bit 0 enters bit 7.
- R9: On a valid, defined operation with ld_flags at 1, z_flag becomes 1 exactly when all eight result bits are 0.
- R10: On a valid, defined operation with ld_flags at 1, s_flag becomes bit 7 of the result.
- R11: When ld_flags is 0, neither s_flag nor z_flag changes, whatever the result.
- R12: With op_valid at 0, or with an opcode from 10 to 15, the accumulator and both flags hold, and reg_we stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | The operation on op_code is performed this cycle |
| op_code | input | 4 | Operation select (see R2–R8, R12) |
| use_imm | input | 1 | 1 selects imm_val as the second operand, 0 selects reg_val |
| reg_val | input | 8 | Contents of the named register |
| imm_val | input | 8 | Immediate byte |
| ld_flags | input | 1 | Allows the sign and zero flags to update |
| result | output | 8 | Combinational result of the current operation |
| reg_we | output | 1 | Write enable for the named register (increment/decrement) |
| acc_q | output | 8 | Accumulator contents |
| s_flag | output | 1 | Registered sign flag |
| z_flag | output | 1 | Registered zero flag |

## Verification
The bench sweeps every accumulator value against operands that include 0, 1, 7Fh, 80h, FFh, the accumulator itself and its complement. These cover the wrap at 255+1 and 0−1, the sign change across 7Fh/80h, and a subtraction that reaches zero. A design that kept a ninth carry bit, or that rotated without wrapping the end bit, would give wrong accumulator values at those points. The operand select alternates, and the unused operand input is driven with unrelated data. A design that read the wrong input for increment or decrement would then show the wrong result, and so would one that wrote the accumulator for them. The load-flags strobe is toggled throughout, including on zero and negative results, so flags that move without the strobe are caught. A reset is also issued in the middle of a run, after the flags have been set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int ACC_W = 8;
  localparam int OP_W  = 4;

  typedef logic [ACC_W-1:0] word_t;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMA = 4'd7,
    OP_RAL = 4'd8,
    OP_RAR = 4'd9
  } alu_op_e;

  function automatic word_t fn_add(word_t a, word_t b);
    return a + b;
  endfunction

  function automatic word_t fn_sub(word_t a, word_t b);
    return a - b;
  endfunction

  function automatic word_t fn_inc(word_t a);
    return a + word_t'(1);
  endfunction

  function automatic word_t fn_dec(word_t a);
    return a - word_t'(1);
  endfunction

  function automatic word_t fn_rol(word_t a);
    return {a[ACC_W-2:0], a[ACC_W-1]};
  endfunction

  function automatic word_t fn_ror(word_t a);
    return {a[0], a[ACC_W-1:1]};
  endfunction

  function automatic logic fn_is_zero(word_t v);
    return ~|v;
  endfunction
endpackage

// File: rtl/acc_opnd_sel.sv
module acc_opnd_sel
  import acc_alu_pkg::*;
(
  input  logic  use_imm,
  input  word_t reg_val,
  input  word_t imm_val,
  output word_t opnd
);
  assign opnd = use_imm ? imm_val : reg_val;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  word_t           acc,
  input  word_t           opnd,
  input  word_t           reg_val,
  output word_t           result,
  output logic            wr_acc,
  output logic            wr_reg,
  output logic            legal
);
  always_comb begin
    result = acc;
    wr_acc = 1'b0;
    wr_reg = 1'b0;
    legal  = 1'b1;
    case (alu_op_e'(op))
      OP_ADD: begin result = fn_add(acc, opnd);  wr_acc = 1'b1; end
      OP_SUB: begin result = fn_sub(acc, opnd);  wr_acc = 1'b1; end
      OP_INC: begin result = fn_inc(reg_val);    wr_reg = 1'b1; end
      OP_DEC: begin result = fn_dec(reg_val);    wr_reg = 1'b1; end
      OP_AND: begin result = acc & opnd;         wr_acc = 1'b1; end
      OP_OR:  begin result = acc | opnd;         wr_acc = 1'b1; end
      OP_XOR: begin result = acc ^ opnd;         wr_acc = 1'b1; end
      OP_CMA: begin result = ~acc;               wr_acc = 1'b1; end
      OP_RAL: begin result = fn_rol(acc);        wr_acc = 1'b1; end
      OP_RAR: begin result = fn_ror(acc);        wr_acc = 1'b1; end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg
  import acc_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd,
  input  word_t res,
  output logic  s_q,
  output logic  z_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= 1'b0;
      z_q <= 1'b0;
    end else if (upd) begin
      s_q <= res[ACC_W-1];
      z_q <= fn_is_zero(res);
    end
  end

  AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(s_q) && $stable(z_q))); // R11
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [OP_W-1:0]      op_code,
  input  logic                 use_imm,
  input  logic [ACC_W-1:0]     reg_val,
  input  logic [ACC_W-1:0]     imm_val,
  input  logic                 ld_flags,
  output logic [ACC_W-1:0]     result,
  output logic                 reg_we,
  output logic [ACC_W-1:0]     acc_q,
  output logic                 s_flag,
  output logic                 z_flag
);
  word_t opnd;
  word_t core_res;
  logic  core_wr_acc, core_wr_reg, core_legal;

  // named events for the assertions
  logic acc_upd_ev;
  logic flag_upd_ev;
  logic rotate_ev;

  acc_opnd_sel u_sel (
    .use_imm (use_imm),
    .reg_val (reg_val),
    .imm_val (imm_val),
    .opnd    (opnd)
  );

  acc_alu_core u_core (
    .op      (op_code),
    .acc     (acc_q),
    .opnd    (opnd),
    .reg_val (reg_val),
    .result  (core_res),
    .wr_acc  (core_wr_acc),
    .wr_reg  (core_wr_reg),
    .legal   (core_legal)
  );

  assign acc_upd_ev  = op_valid & core_wr_acc;
  assign flag_upd_ev = op_valid & core_legal & ld_flags;
  assign rotate_ev   = op_valid & ((op_code == OP_RAL) | (op_code == OP_RAR));
  assign result      = core_res;
  assign reg_we      = op_valid & core_wr_reg;

  always_ff @(posedge clk) begin
    if (rst)             acc_q <= '0;
    else if (acc_upd_ev) acc_q <= core_res;
  end

  acc_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .upd (flag_upd_ev),
    .res (core_res),
    .s_q (s_flag),
    .z_q (z_flag)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !s_flag && !z_flag)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_q) && $stable(s_flag) && $stable(z_flag))); // R12
  AST_REG_DEST_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> $stable(acc_q)); // R4
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> op_valid); // R4
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flag_upd_ev |=> (z_flag == ($past(result) == '0))); // R9
  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flag_upd_ev |=> (s_flag == $past(result[ACC_W-1]))); // R10
  AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    rotate_ev |-> ($countones(result) == $countones(acc_q))); // R7
endmodule

// File: tb/acc_alu_unit_tb.sv
module acc_alu_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic       use_imm = 1'b0;
  logic [7:0] reg_val = 8'd0;
  logic [7:0] imm_val = 8'd0;
  logic       ld_flags = 1'b0;
  logic [7:0] result;
  logic       reg_we;
  logic [7:0] acc_q;
  logic       s_flag;
  logic       z_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int m_acc = 0;
  int m_s = 0;
  int m_z = 0;

  always #2 clk = ~clk;

  acc_alu_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .use_imm(use_imm), .reg_val(reg_val), .imm_val(imm_val),
    .ld_flags(ld_flags), .result(result), .reg_we(reg_we),
    .acc_q(acc_q), .s_flag(s_flag), .z_flag(z_flag)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0;
    @(posedge clk); #1;
    m_acc = 0; m_s = 0; m_z = 0;
    chk("R1", "acc", acc_q, 0);
    chk("R1", "s", s_flag, 0);
    chk("R1", "z", z_flag, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_op(int op, bit ui, int rv, int iv, bit lf, bit vld);
    int opnd, r;
    bit legal, wra, wrr;
    @(negedge clk);
    op_valid = vld; op_code = op[3:0]; use_imm = ui;
    reg_val = rv[7:0]; imm_val = iv[7:0]; ld_flags = lf;
    opnd = ui ? iv : rv;
    legal = 1; wra = 1; wrr = 0; r = m_acc;
    case (op)
      0: r = (m_acc + opnd) % 256;
      1: r = (m_acc - opnd + 256) % 256;
      2: begin r = (rv + 1) % 256;   wra = 0; wrr = 1; end
      3: begin r = (rv + 255) % 256; wra = 0; wrr = 1; end
      4: r = m_acc & opnd;
      5: r = m_acc | opnd;
      6: r = m_acc ^ opnd;
      7: r = 255 - m_acc;
      8: r = ((m_acc * 2) % 256) + (m_acc / 128);
      9: r = (m_acc / 2) + ((m_acc % 2) * 128);
      default: begin legal = 0; wra = 0; end
    endcase
    #1;
    if (vld && legal) chk(req_of(op), "result", result, r);
    chk((vld && legal) ? "R4" : "R12", "reg_we", reg_we, int'(vld && wrr));
    @(posedge clk); #1;
    if (vld && legal && wra) m_acc = r;
    if (vld && legal && lf) begin
      m_z = (r == 0);
      m_s = (r >= 128);
    end
    chk((vld && legal) ? req_of(op) : "R12", "acc", acc_q, m_acc);
    chk(!(vld && legal) ? "R12" : (lf ? "R10" : "R11"), "s", s_flag, m_s);
    chk(!(vld && legal) ? "R12" : (lf ? "R9" : "R11"), "z", z_flag, m_z);
  endtask

  task automatic set_acc(int v);
    do_op(0, 1, 8'h3C, (v - m_acc + 256) % 256, 0, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL R1..all watchdog expired: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset();

    // exhaustive sweep over accumulator values and operand corners
    for (int op = 0; op < 10; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 8; k++) begin
          int b;
          bit ui, lf;
          case (k)
            0: b = 0;
            1: b = 1;
            2: b = 8'h7F;
            3: b = 8'h80;
            4: b = 8'hFF;
            5: b = a;
            6: b = 255 - a;
            default: b = 8'h5A;
          endcase
          ui = ((k + a) % 2) == 1;
          lf = ((k + a + op) % 3) != 0;
          set_acc(a);
          do_op(op, ui, ui ? (b ^ 8'hC3) : b, ui ? b : (b ^ 8'h3C), lf, 1);
        end
      end
    end

    // R12: idle cycles and undefined opcodes leave state untouched
    set_acc(8'h81);
    do_op(1, 1, 0, 8'h81, 1, 0);
    for (int op = 10; op < 16; op++) begin
      do_op(op, 1, 8'hFF, 8'h81, 1, 1);
      do_op(op, 0, 8'h00, 8'h00, 1, 1);
    end

    // R9 R10 R11: zero result with flags loaded, then negative without loading
    do_op(1, 1, 0, 8'h81, 1, 1);
    do_op(7, 0, 0, 0, 0, 1);
    do_op(2, 0, 8'hFF, 0, 1, 1);

    // R1: reset in mid-run after flags set
    set_acc(8'h9A);
    do_op(5, 0, 8'h00, 0, 1, 1);
    do_reset();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule